// File: doc/BRIEF.md
# UART Receive Character Queue with Per-Character Error Flags

This block is the receive-side buffer of one UART channel. The shift register writes each finished character into it. The character arrives as 8 data bits plus three error flags: parity, framing and break. Each entry is stored with its own flags in a 64-deep, 11-bit-wide queue. The host reads characters through a read-only holding-register port. A line-status view shows the following:

- the error flags of the character now at the head,
- a data-ready bit,
- an overrun bit.

The head flags follow the head entry. They change on the same edge that a host read retires the old head.

A receive-data interrupt rises when the fill count reaches a trigger level. The host picks that level from four values with a 2-bit field. A mode input selects queue operation or single-register operation. With the mode input low, the block holds one character only, and the interrupt rises as soon as that character is present. Any change of the mode input empties the buffer.

Top module: `rx_char_fifo`

## Requirements
- R1: In queue mode, `holdData` shows the oldest unread character, and characters leave in the order they were written.
- R2: `statusOut[2]` (parity), `statusOut[3]` (framing) and `statusOut[4]` (break) show the flags stored with the head character. They take the next entry's flags on the clock edge that performs a host read.
- R3: A write while the buffer is full is discarded and sets `statusOut[1]` (overrun). A `rdStatus` pulse clears the overrun bit. When a discarded write and `rdStatus` fall in the same cycle, the overrun bit stays set.
- R4: `statusOut[0]` (data ready) is high exactly when at least one character is stored.
- R5: In queue mode, `dataIrq` is high while the fill count is at or above the trigger level. The trigger level is set by `trigSel`: 0 gives 8, 1 gives 16, 2 gives 24 and 3 gives 56.
- R6: With `fifoEn` low, the capacity is one character, and `dataIrq` is high while that character is present.
- R7: A host read of an empty buffer changes nothing. `holdData` keeps the last character read, the flag bits read 0, and the next write becomes the head.
- R8: A write and a host read in the same cycle on a full buffer both take effect. The count stays at capacity and no overrun is flagged.
- R9: Any change of `fifoEn` empties the buffer on the next edge.
- R10: After reset the buffer is empty, and `statusOut`, `dataIrq` and `holdData` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| fifoEn | input | 1 | 1: queue mode, 0: single holding register |
| trigSel | input | 2 | Interrupt trigger level select |
| wrValid | input | 1 | Write strobe from the shift register |
| wrData | input | 8 | Received character |
| wrTags | input | 3 | Flags: bit0 parity, bit1 framing, bit2 break |
| rdHold | input | 1 | Host read of the holding register (retires the head) |
| rdStatus | input | 1 | Host read of line status (clears overrun) |
| holdData | output | 8 | Head character, or last character read when empty |
| statusOut | output | 5 | bit0 ready, bit1 overrun, bits 4:2 head flags |
| dataIrq | output | 1 | Receive-data interrupt |

## Verification
A write can arrive in the same cycle as a host read. This collision is provoked on a completely full queue, where the full condition alone would reject the write. It is judged by draining all 64 entries afterwards: the new character must appear last and the old head must be gone. The overrun bit must also stay clear. A second collision pairs a discarded write with a status read in one cycle, and the overrun bit must come out set.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int DATA_W = 8;
  localparam int TAG_W  = 3;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [TAG_W-1:0]  tags;
  } rxEntry_t;

  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } rxStrobes_t;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LVL0  = 8,
  parameter int LVL1  = 16,
  parameter int LVL2  = 24,
  parameter int LVL3  = 56,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoEn,
  input  logic [1:0]        trigSel,
  input  logic              wrValid,
  input  logic              rdHold,
  input  logic              rdStatus,
  output rxStrobes_t        strb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  fillCount,
  output logic              overrun,
  output logic              dataIrq
);
  logic             fifoEnQ;
  logic [CNT_W-1:0] capacity;
  logic [CNT_W-1:0] trigLevel;
  logic             isFull;
  logic             dropWrite;

  assign capacity = fifoEn ? CNT_W'(DEPTH) : CNT_W'(1);
  assign isFull   = (fillCount >= capacity);

  always_comb begin
    strb.flush = (fifoEn != fifoEnQ);
    strb.pop   = rdHold && (fillCount != '0) && !strb.flush;
    strb.push  = wrValid && (!isFull || strb.pop) && !strb.flush;
    dropWrite  = wrValid && !strb.push && !strb.flush;
  end

  always_comb begin
    unique case (trigSel)
      2'd0:    trigLevel = CNT_W'(LVL0);
      2'd1:    trigLevel = CNT_W'(LVL1);
      2'd2:    trigLevel = CNT_W'(LVL2);
      default: trigLevel = CNT_W'(LVL3);
    endcase
  end

  assign dataIrq = fifoEn ? (fillCount >= trigLevel) : (fillCount != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fifoEnQ   <= 1'b0;
      wrAddr    <= '0;
      rdAddr    <= '0;
      fillCount <= '0;
    end else begin
      fifoEnQ <= fifoEn;
      if (strb.flush) begin
        wrAddr    <= '0;
        rdAddr    <= '0;
        fillCount <= '0;
      end else begin
        if (strb.push) wrAddr <= wrAddr + 1'b1;
        if (strb.pop)  rdAddr <= rdAddr + 1'b1;
        if (strb.push && !strb.pop)      fillCount <= fillCount + 1'b1;
        else if (strb.pop && !strb.push) fillCount <= fillCount - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          overrun <= 1'b0;
    else if (dropWrite) overrun <= 1'b1;
    else if (rdStatus)  overrun <= 1'b0;
  end
endmodule

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobes_t        strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              headValid,
  input  rxEntry_t          wrEntry,
  output logic [DATA_W-1:0] dataOut,
  output logic [TAG_W-1:0]  tagOut
);
  rxEntry_t          mem [DEPTH];
  rxEntry_t          headEntry;
  logic [DATA_W-1:0] lastData;

  always_ff @(posedge clk) begin
    if (strb.push) mem[wrAddr] <= wrEntry;
  end

  assign headEntry = mem[rdAddr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         lastData <= '0;
    else if (strb.pop) lastData <= headEntry.data;
  end

  assign dataOut = headValid ? headEntry.data : lastData;
  assign tagOut  = headValid ? headEntry.tags : '0;
endmodule

// File: rtl/rx_char_fifo.sv
module rx_char_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LVL0  = 8,
  parameter int LVL1  = 16,
  parameter int LVL2  = 24,
  parameter int LVL3  = 56
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       fifoEn,
  input  logic [1:0] trigSel,
  input  logic       wrValid,
  input  logic [7:0] wrData,
  input  logic [2:0] wrTags,
  input  logic       rdHold,
  input  logic       rdStatus,
  output logic [7:0] holdData,
  output logic [4:0] statusOut,
  output logic       dataIrq
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int CNT_W  = ADDR_W + 1;

  rxStrobes_t        strb;
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] rdAddr;
  logic [CNT_W-1:0]  fillCount;
  logic              overrun;
  logic              headValid;
  logic [TAG_W-1:0]  headTags;
  rxEntry_t          wrEntry;

  assign wrEntry   = '{data: wrData, tags: wrTags};
  assign headValid = (fillCount != '0);

  rxq_ctrl #(
    .DEPTH(DEPTH), .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .trigSel(trigSel),
    .wrValid(wrValid), .rdHold(rdHold), .rdStatus(rdStatus),
    .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .fillCount(fillCount), .overrun(overrun), .dataIrq(dataIrq)
  );

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rstN(rstN), .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .headValid(headValid), .wrEntry(wrEntry),
    .dataOut(holdData), .tagOut(headTags)
  );

  assign statusOut = {headTags, overrun, headValid};
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             fifoEn,
  input logic             wrValid,
  input logic             rdHold,
  input logic             rdStatus,
  input logic [7:0]       holdData,
  input logic [4:0]       statusOut,
  input logic             dataIrq,
  input logic [CNT_W-1:0] fillCount,
  input rxStrobes_t       strb
);
  logic [CNT_W-1:0] cap;
  assign cap = fifoEn ? CNT_W'(DEPTH) : CNT_W'(1);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CNT_W'(DEPTH));

  p_overrun_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !strb.push && !strb.flush) |=> statusOut[1]);

  p_empty_tags_r7: assert property (@(posedge clk) disable iff (!rstN)
    !statusOut[0] |-> (statusOut[4:2] == 3'b000));

  p_empty_read_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdHold && !wrValid && !statusOut[0] && !strb.flush) |=> $stable(holdData));

  p_irq_top_r5: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEn && fillCount >= CNT_W'(56)) |-> dataIrq);

  p_irq_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoEn && statusOut[0]) |-> dataIrq);

  p_full_swap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && rdHold && fillCount == cap && !strb.flush && !rdStatus)
      |=> (fillCount == $past(fillCount)) && !$rose(statusOut[1]));

  p_flush_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |=> (fillCount == '0));
endmodule

bind rx_char_fifo rxq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .wrValid(wrValid),
  .rdHold(rdHold), .rdStatus(rdStatus), .holdData(holdData),
  .statusOut(statusOut), .dataIrq(dataIrq), .fillCount(fillCount),
  .strb(strb)
);

// File: tb/rx_char_fifo_tb.sv
`timescale 1ns/1ps
module rx_char_fifo_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       fifoEn = 1'b1;
  logic [1:0] trigSel = 2'd0;
  logic       wrValid = 1'b0;
  logic [7:0] wrData = '0;
  logic [2:0] wrTags = '0;
  logic       rdHold = 1'b0;
  logic       rdStatus = 1'b0;
  logic [7:0] holdData;
  logic [4:0] statusOut;
  logic       dataIrq;

  int testCount = 0;
  int failCount = 0;
  logic [10:0] sb[$];
  logic [7:0]  lastD = '0;
  bit          ovr = 1'b0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  rx_char_fifo u_dut (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .trigSel(trigSel),
    .wrValid(wrValid), .wrData(wrData), .wrTags(wrTags),
    .rdHold(rdHold), .rdStatus(rdStatus),
    .holdData(holdData), .statusOut(statusOut), .dataIrq(dataIrq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int trigOf(input logic [1:0] s);
    case (s)
      2'd0: return 8;
      2'd1: return 16;
      2'd2: return 24;
      default: return 56;
    endcase
  endfunction

  // monitor: compare outputs against the scoreboard queue
  task automatic compare();
    int n = sb.size();
    bit irqExp = fifoEn ? (n >= trigOf(trigSel)) : (n >= 1);
    chk(statusOut[0] == (n > 0), "R4 ready", statusOut[0], n > 0);
    chk(statusOut[1] == ovr, "R3 overrun", statusOut[1], ovr);
    chk(dataIrq == irqExp, fifoEn ? "R5 irq" : "R6 irq", dataIrq, irqExp);
    if (n > 0) begin
      chk(holdData == sb[0][10:3], "R1 head data", holdData, sb[0][10:3]);
      chk(statusOut[4:2] == sb[0][2:0], "R2 head tags", statusOut[4:2], sb[0][2:0]);
    end else begin
      chk(holdData == lastD, "R7 empty data", holdData, lastD);
      chk(statusOut[4:2] == 3'b000, "R7 empty tags", statusOut[4:2], 0);
    end
  endtask

  // driver: one cycle of stimulus, model update, then compare
  task automatic cycle(input bit w, input logic [7:0] d, input logic [2:0] t,
                       input bit r, input bit s);
    int cap = fifoEn ? 64 : 1;
    bit pop, push;
    wrValid = w; wrData = d; wrTags = t; rdHold = r; rdStatus = s;
    @(negedge clk);
    wrValid = 0; rdHold = 0; rdStatus = 0;
    pop  = r && (sb.size() > 0);
    push = w && ((sb.size() < cap) || pop);
    if (pop) begin
      lastD = sb[0][10:3];
      void'(sb.pop_front());
    end
    if (push) sb.push_back({d, t});
    if (w && !push) ovr = 1'b1;
    else if (s) ovr = 1'b0;
    compare();
  endtask

  task automatic wr(input int i);
    cycle(1'b1, 8'(i * 7 + 3), 3'(i), 1'b0, 1'b0);
  endtask

  task automatic rd();
    cycle(1'b0, 8'h00, 3'b000, 1'b1, 1'b0);
  endtask

  task automatic setMode(input bit en);
    fifoEn = en;
    @(negedge clk);
    sb.delete();
    chk(statusOut[0] == 1'b0, "R9 flush", statusOut[0], 0);
    compare();
  endtask

  initial begin
    #(200000 * 20);
    chk(1'b0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(statusOut == 5'd0, "R10 reset status", statusOut, 0);
    chk(dataIrq == 1'b0, "R10 reset irq", dataIrq, 0);
    chk(holdData == 8'd0, "R10 reset data", holdData, 0);
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    compare();

    // R5 trigger 8, R1/R2 ordering with flags
    for (int i = 0; i < 8; i++) wr(i);
    for (int i = 0; i < 8; i++) rd();
    // R7 empty read, then a new write becomes head
    rd();
    chk(holdData == lastD, "R7 hold after empty read", holdData, lastD);
    wr(100);
    rd();

    // R5 trigger 56, fill to full, R3 overrun
    trigSel = 2'd3;
    for (int i = 0; i < 64; i++) wr(i + 10);
    wr(200);
    cycle(1'b0, 8'h00, 3'b000, 1'b0, 1'b1);
    // R3: discarded write and status read together -> set wins
    cycle(1'b1, 8'h55, 3'b111, 1'b0, 1'b1);
    chk(statusOut[1] == 1'b1, "R3 set wins", statusOut[1], 1);
    cycle(1'b0, 8'h00, 3'b000, 1'b0, 1'b1);
    // R8: write and read on a full queue
    cycle(1'b1, 8'hA5, 3'b101, 1'b1, 1'b0);
    chk(statusOut[1] == 1'b0, "R8 no overrun on swap", statusOut[1], 0);
    chk(sb.size() == 64, "R8 model full", sb.size(), 64);
    for (int i = 0; i < 64; i++) rd();
    chk(lastD == 8'hA5, "R8 swapped char last", lastD, 8'hA5);

    // R5 triggers 16 and 24
    trigSel = 2'd1;
    for (int i = 0; i < 16; i++) wr(i + 40);
    trigSel = 2'd2;
    @(negedge clk);
    compare();
    for (int i = 0; i < 8; i++) wr(i + 60);

    // R9 mode change flushes; R6 single register
    setMode(1'b0);
    wr(1);
    chk(dataIrq == 1'b1, "R6 irq one char", dataIrq, 1);
    wr(2);
    rd();
    chk(lastD == 8'(1 * 7 + 3), "R6 first kept", lastD, 10);
    setMode(1'b1);
    wr(5);
    rd();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule